// File: doc/BRIEF.md
# System Exception Pending and Status Registers

This block is the software-visible register bank for the built-in system exceptions of a small processor core. Software uses it to raise or withdraw the pending state of the non-maskable interrupt, the deferred-service exception and the tick exception. It also reads back a packed summary of which exception is running, which one would be taken next and which flags are pending. The same bank holds the vector table base, a key-protected system reset request and the handler status word with its three fault enables.

The block owns the three software-settable pending bits, the vector base and the fault enables. All other exception state (active flags, fault pending flags, the active and highest pending vector numbers, the external pending summary) arrives on inputs from the exception-state array and the arbiter. Hardware sources, such as the tick timer, set pending bits through `hw_set` in the same cycle as any bus write. The bus is a simple word-select interface: a write takes effect at the clock edge where `wr_en` is high, and a read returns data on `rdata` from the edge where `rd_en` is high. That data reflects state before any write in the same cycle.

Top module: `sysexc_ctrl_regs`

## Requirements
- R1: After a synchronous reset, `pend_out`, `fault_en`, `vbase`, `sys_rst_req` and `rdata` are all zero.
- R2: A write to select 0 sets NMI pending with bit 31, deferred-service pending with bit 28 and tick pending with bit 26. It clears deferred-service pending with bit 27 and tick pending with bit 25. `pend_out` bit 2 is NMI, bit 1 is deferred-service and bit 0 is tick.
- R3: When the set bit and the clear bit of the same exception are both 1 in one write, the exception ends up pending.
- R4: A `hw_set` bit (same bit order as `pend_out`) sets its pending bit whether or not a write occurs, and it wins over a software clear in the same cycle.
- R5: A read of select 0 returns the following fields. Bits [VEC_W-1:0] hold `act_vec`, or 0 when `act_valid` is low. Bit 11 is 1 when `act_valid` is low or `act_nested` is low. Bits [12+VEC_W-1:12] hold `pnd_vec`, or 0 when `pnd_valid` is low. Bit 22 is `ext_pend`. Bits 26, 28 and 31 are tick, deferred-service and NMI pending. Every other bit is 0.
- R6: A write to select 1 stores bits [31:7] of the write data into `vbase` and forces bits [6:0] to 0. A read of select 1 returns `vbase`.
- R7: A write to select 2 with bits [31:16] equal to 0x05FA and bit 2 set raises `sys_rst_req` for exactly one cycle after the write edge. Any other write to select 2 leaves it low. A read of select 2 returns 0xFA050000.
- R8: A read of select 3 returns `hs_active` bits 0..6 at bit positions 0, 1, 3, 7, 8, 10 and 11. Those are memory-manage, bus fault, usage fault, supervisor call, debug monitor, deferred-service and tick active. It returns `hs_pend` bits 0..3 at bit positions 12..15 (usage, memory-manage, bus, supervisor call pending) and `fault_en` at bits 16..18. Every other bit is 0.
- R9: A write to select 3 loads `fault_en` from write data bits [18:16], ordered memory-manage, bus, usage from bit 16 up. It does not touch the pending bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 2 | Register select: 0 state, 1 vector base, 2 reset control, 3 handler status |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| hw_set | input | 3 | Hardware pending-set requests {NMI, deferred-service, tick} |
| act_valid | input | 1 | An exception is active |
| act_vec | input | VEC_W | Active exception number |
| act_nested | input | 1 | The active exception preempted another |
| pnd_valid | input | 1 | Some exception is pending |
| pnd_vec | input | VEC_W | Highest pending exception number |
| ext_pend | input | 1 | Any external interrupt pending |
| hs_active | input | 7 | Active flags: mem, bus, usage, svc, debug, deferred, tick |
| hs_pend | input | 4 | Pending flags: usage, mem, bus, svc |
| pend_out | output | 3 | Pending bits {NMI, deferred-service, tick} |
| fault_en | output | 3 | Fault enables {usage, bus, mem} |
| vbase | output | 32 | Vector table base |
| sys_rst_req | output | 1 | One-cycle system reset request |

## Verification
A software pending write and a hardware pending set can land in the same cycle, and so can the set and clear bits inside one write. A table of state-register writes drives set-only, clear-only and set-plus-clear patterns, some with a `hw_set` bit raised on the same edge. After each edge the bench compares `pend_out` with a value it derives from the rule that any set beats any clear. The status reads that follow then confirm that the packed word carries the same pending flags.

// File: rtl/sysexc_pkg.sv
package sysexc_pkg;
  localparam int DATA_W  = 32;
  localparam int ADDR_W  = 2;
  localparam int NPEND   = 3;   // 0 tick, 1 deferred-service, 2 NMI
  localparam int KEY_W   = 16;
  localparam logic [KEY_W-1:0] WR_KEY = 16'h05FA;
  localparam logic [KEY_W-1:0] RD_KEY = 16'hFA05;
  localparam int RST_BIT  = 2;
  localparam int VB_LOW   = 7;
  localparam int RTB_BIT  = 11;
  localparam int PVEC_LSB = 12;
  localparam int EXT_BIT  = 22;
  localparam int FEN_LSB  = 16;

  typedef enum logic [ADDR_W-1:0] {
    SEL_STATE  = 2'd0,
    SEL_VBASE  = 2'd1,
    SEL_RSTCTL = 2'd2,
    SEL_HSTAT  = 2'd3
  } sel_e;

  // set bit position in a state write, per pending index
  function automatic int set_pos(input int i);
    case (i)
      0:       return 26;
      1:       return 28;
      default: return 31;
    endcase
  endfunction

  // clear bit position, -1 when the exception has no clear bit
  function automatic int clr_pos(input int i);
    case (i)
      0:       return 25;
      1:       return 27;
      default: return -1;
    endcase
  endfunction
endpackage

// File: rtl/sx_pend_cell.sv
module sx_pend_cell (
  input  logic clk,
  input  logic rst,
  input  logic sw_set,
  input  logic sw_clr,
  input  logic hw_set,
  output logic pend_q
);
  always_ff @(posedge clk) begin
    if (rst)                   pend_q <= 1'b0;
    else if (sw_set || hw_set) pend_q <= 1'b1;
    else if (sw_clr)           pend_q <= 1'b0;
  end

  // R3: set beats clear in one write
  a_r3_set_wins: assert property (@(posedge clk) disable iff (rst)
    (sw_set && sw_clr) |=> pend_q);
  // R4: hardware set beats software clear
  a_r4_hw_wins: assert property (@(posedge clk) disable iff (rst)
    hw_set |=> pend_q);
  // R2: a lone clear empties the bit
  a_r2_clear: assert property (@(posedge clk) disable iff (rst)
    (sw_clr && !sw_set && !hw_set) |=> !pend_q);
endmodule

// File: rtl/sx_key_reset.sv
module sx_key_reset
  import sysexc_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_hit,
  input  logic [KEY_W-1:0] key_in,
  input  logic             req_bit,
  output logic             req_q
);
  always_ff @(posedge clk) begin
    if (rst) req_q <= 1'b0;
    else     req_q <= wr_hit && (key_in == WR_KEY) && req_bit;
  end

  // R7: no request without a keyed write carrying the request bit
  a_r7_keyed_only: assert property (@(posedge clk) disable iff (rst)
    (req_q && !$past(rst)) |-> ($past(wr_hit) && $past(key_in) == WR_KEY && $past(req_bit)));
endmodule

// File: rtl/sx_read_mux.sv
module sx_read_mux
  import sysexc_pkg::*;
#(
  parameter int VEC_W = 9
) (
  input  sel_e              sel,
  input  logic              act_valid,
  input  logic [VEC_W-1:0]  act_vec,
  input  logic              act_nested,
  input  logic              pnd_valid,
  input  logic [VEC_W-1:0]  pnd_vec,
  input  logic              ext_pend,
  input  logic [NPEND-1:0]  pend_q,
  input  logic [DATA_W-1:0] vbase,
  input  logic [6:0]        hs_active,
  input  logic [3:0]        hs_pend,
  input  logic [2:0]        fault_en,
  output logic [DATA_W-1:0] rd_word
);
  logic [DATA_W-1:0] st_word, hs_word;

  always_comb begin
    st_word = '0;
    st_word[VEC_W-1:0]        = act_valid ? act_vec : '0;
    st_word[RTB_BIT]          = !act_valid || !act_nested;
    st_word[PVEC_LSB +: VEC_W] = pnd_valid ? pnd_vec : '0;
    st_word[EXT_BIT]          = ext_pend;
    for (int i = 0; i < NPEND; i++) st_word[set_pos(i)] = pend_q[i];
  end

  always_comb begin
    hs_word = '0;
    hs_word[0]  = hs_active[0];
    hs_word[1]  = hs_active[1];
    hs_word[3]  = hs_active[2];
    hs_word[7]  = hs_active[3];
    hs_word[8]  = hs_active[4];
    hs_word[10] = hs_active[5];
    hs_word[11] = hs_active[6];
    hs_word[15:12]          = hs_pend;
    hs_word[FEN_LSB +: 3]   = fault_en;
  end

  always_comb begin
    case (sel)
      SEL_STATE:  rd_word = st_word;
      SEL_VBASE:  rd_word = vbase;
      SEL_RSTCTL: rd_word = {RD_KEY, {(DATA_W-KEY_W){1'b0}}};
      default:    rd_word = hs_word;
    endcase
  end
endmodule

// File: rtl/sysexc_ctrl_regs.sv
module sysexc_ctrl_regs
  import sysexc_pkg::*;
#(
  parameter int VEC_W = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [1:0]        addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  input  logic [2:0]        hw_set,
  input  logic              act_valid,
  input  logic [VEC_W-1:0]  act_vec,
  input  logic              act_nested,
  input  logic              pnd_valid,
  input  logic [VEC_W-1:0]  pnd_vec,
  input  logic              ext_pend,
  input  logic [6:0]        hs_active,
  input  logic [3:0]        hs_pend,
  output logic [2:0]        pend_out,
  output logic [2:0]        fault_en,
  output logic [31:0]       vbase,
  output logic              sys_rst_req
);
  sel_e sel;
  logic wr_state, wr_vbase, wr_rst, wr_hstat;
  logic [DATA_W-1:0] rd_word;
  logic unused_wbits;

  assign sel      = sel_e'(addr);
  assign wr_state = wr_en && (sel == SEL_STATE);
  assign wr_vbase = wr_en && (sel == SEL_VBASE);
  assign wr_rst   = wr_en && (sel == SEL_RSTCTL);
  assign wr_hstat = wr_en && (sel == SEL_HSTAT);
  assign unused_wbits = ^{wdata[6:3], wdata[1:0]};

  for (genvar i = 0; i < NPEND; i++) begin : g_pend
    logic clr_req;
    if (clr_pos(i) >= 0) begin : g_clr
      assign clr_req = wr_state && wdata[clr_pos(i)];
    end else begin : g_noclr
      assign clr_req = 1'b0;
    end
    sx_pend_cell u_cell (
      .clk    (clk),
      .rst    (rst),
      .sw_set (wr_state && wdata[set_pos(i)]),
      .sw_clr (clr_req),
      .hw_set (hw_set[i]),
      .pend_q (pend_out[i])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vbase    <= '0;
      fault_en <= '0;
      rdata    <= '0;
    end else begin
      if (wr_vbase) vbase    <= {wdata[DATA_W-1:VB_LOW], {VB_LOW{1'b0}}};
      if (wr_hstat) fault_en <= wdata[FEN_LSB +: 3];
      if (rd_en)    rdata    <= rd_word;
    end
  end

  sx_key_reset u_key (
    .clk     (clk),
    .rst     (rst),
    .wr_hit  (wr_rst),
    .key_in  (wdata[DATA_W-1 -: KEY_W]),
    .req_bit (wdata[RST_BIT]),
    .req_q   (sys_rst_req)
  );

  sx_read_mux #(.VEC_W(VEC_W)) u_mux (
    .sel        (sel),
    .act_valid  (act_valid),
    .act_vec    (act_vec),
    .act_nested (act_nested),
    .pnd_valid  (pnd_valid),
    .pnd_vec    (pnd_vec),
    .ext_pend   (ext_pend),
    .pend_q     (pend_out),
    .vbase      (vbase),
    .hs_active  (hs_active),
    .hs_pend    (hs_pend),
    .fault_en   (fault_en),
    .rd_word    (rd_word)
  );

  // R6: base keeps the upper write bits, low bits zero
  a_r6_vbase_write: assert property (@(posedge clk) disable iff (rst)
    wr_vbase |=> (vbase[31:7] == $past(wdata[31:7]) && vbase[6:0] == 7'd0));
  // R9: enables follow a handler status write
  a_r9_fault_en: assert property (@(posedge clk) disable iff (rst)
    wr_hstat |=> (fault_en == $past(wdata[18:16])));
  // R7: reset control reads show the read key
  a_r7_rd_key: assert property (@(posedge clk) disable iff (rst)
    (rd_en && sel == SEL_RSTCTL) |=> (rdata == 32'hFA05_0000));
  // R5: state read carries NMI pending at bit 31
  a_r5_nmi_bit: assert property (@(posedge clk) disable iff (rst)
    (rd_en && sel == SEL_STATE) |=> (rdata[31] == $past(pend_out[2])));
endmodule

// File: tb/tb_sysexc_ctrl_regs.sv
module tb_sysexc_ctrl_regs;
  localparam int VEC_W = 9;
  localparam int NROWS = 7;
  // {write data, hw_set, expected pend_out}
  localparam logic [37:0] TBL [NROWS] = '{
    {32'h9400_0000, 3'b000, 3'b111},
    {32'h0A00_0000, 3'b000, 3'b100},
    {32'h1800_0000, 3'b000, 3'b110},
    {32'h0600_0000, 3'b000, 3'b111},
    {32'h0A00_0000, 3'b001, 3'b101},
    {32'h0000_0000, 3'b010, 3'b111},
    {32'h0A00_0000, 3'b000, 3'b100}
  };

  logic clk = 0, rst = 1, wr_en = 0, rd_en = 0;
  logic [1:0] addr = 0;
  logic [31:0] wdata = 0, rdata, vbase;
  logic [2:0] hw_set = 0, pend_out, fault_en;
  logic act_valid = 0, act_nested = 0, pnd_valid = 0, ext_pend = 0, sys_rst_req;
  logic [VEC_W-1:0] act_vec = 0, pnd_vec = 0;
  logic [6:0] hs_active = 0;
  logic [3:0] hs_pend = 0;
  int checks = 0, errors = 0;
  bit done = 0;
  logic [31:0] rv;

  always #2.5 clk = ~clk;

  sysexc_ctrl_regs #(.VEC_W(VEC_W)) dut (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d, input logic [2:0] hw);
    @(negedge clk);
    wr_en = 1; addr = a; wdata = d; hw_set = hw;
    @(negedge clk);
    wr_en = 0; hw_set = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_en = 1; addr = a;
    @(negedge clk);
    rd_en = 0; d = rdata;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check("R1 pend", {29'd0, pend_out}, 0);
    check("R1 fault_en", {29'd0, fault_en}, 0);
    check("R1 vbase", vbase, 0);
    check("R1 rst_req", {31'd0, sys_rst_req}, 0);
    check("R1 rdata", rdata, 0);

    // R2 R3 R4: pending table
    for (int i = 0; i < NROWS; i++) begin
      wr(2'd0, TBL[i][37:6], TBL[i][5:3]);
      check($sformatf("R2/R3/R4 row %0d", i), {29'd0, pend_out}, {29'd0, TBL[i][2:0]});
    end

    // R5: status word
    act_valid = 1; act_vec = 9'd15; act_nested = 1;
    pnd_valid = 1; pnd_vec = 9'd37; ext_pend = 1;
    rd(2'd0, rv); check("R5 full", rv, 32'h8042_500F);
    act_vec = 9'd3; act_nested = 0; pnd_valid = 0; ext_pend = 0;
    rd(2'd0, rv); check("R5 base", rv, 32'h8000_0803);
    act_valid = 0; act_nested = 1; pnd_vec = 9'd5;
    rd(2'd0, rv); check("R5 idle", rv, 32'h8000_0800);

    // R6
    wr(2'd1, 32'hFFFF_FFFF, 3'b000);
    check("R6 vbase", vbase, 32'hFFFF_FF80);
    rd(2'd1, rv); check("R6 read", rv, 32'hFFFF_FF80);

    // R7
    wr(2'd2, 32'h05FB_0004, 3'b000);
    check("R7 bad key", {31'd0, sys_rst_req}, 0);
    wr(2'd2, 32'h05FA_0003, 3'b000);
    check("R7 no bit2", {31'd0, sys_rst_req}, 0);
    @(negedge clk);
    wr_en = 1; addr = 2'd2; wdata = 32'h05FA_0004;
    @(negedge clk);
    wr_en = 0;
    check("R7 pulse", {31'd0, sys_rst_req}, 1);
    @(negedge clk);
    check("R7 one cycle", {31'd0, sys_rst_req}, 0);
    rd(2'd2, rv); check("R7 read", rv, 32'hFA05_0000);

    // R8 R9
    hs_active = 7'h7F; hs_pend = 4'hF;
    wr(2'd3, 32'h0005_0000, 3'b000);
    check("R9 enables", {29'd0, fault_en}, 32'd5);
    check("R9 pend kept", {29'd0, pend_out}, 32'd4);
    rd(2'd3, rv); check("R8 all", rv, 32'h0005_FD8B);
    hs_active = 7'b0000001; hs_pend = 4'b0001;
    wr(2'd3, 32'hFFFA_FFFF, 3'b000);
    check("R9 bus only", {29'd0, fault_en}, 32'd2);
    rd(2'd3, rv); check("R8 sparse", rv, 32'h0002_1001);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule